// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Reloadable Bit-Rate Timer

This block turns bytes written by a host into 8N1 frames on a single output line. The host writes a byte into a one-entry holding register. When the shift stage is free, the byte moves into a frame shifter, which sends a low start bit, the eight data bits least significant first, and a high stop bit. Between frames the line rests high. Because the holding register is separate from the shifter, the host can queue the next byte while the current one is still going out, and frames then follow each other with no idle gap.

The bit rate comes from an 8-bit down-counting timer. The timer reloads from a host-written period register, and a rate-select input sets how many timer expiries make one bit: 16 when set, 64 when clear. Writing the period register restarts the timer at once. Two status outputs tell the host what it may do. One shows that the holding register is free, and it rises as soon as a byte moves into the shifter. The other shows that the transmitter is completely drained.

Top module: `uart_tx_core`

## Requirements
- R1: After reset `tx_out` is 1, `hold_empty` is 1 and `shift_empty` is 1. Whenever no frame is being shifted, `tx_out` is 1.
- R2: A frame is one bit of 0, then data bits 0 through 7 in that order, then one bit of 1.
- R3: Each bit lasts N×(P+1) clock cycles, where P is the period register value and N is 16 when `fast_sel` is 1 and 64 when it is 0.
- R4: A pulse on `period_wr` loads `period_din` into the timer in that same edge. The next timer expiry comes `period_din`+1 cycles later, whatever count was running before. Expiries already counted in the current bit are kept.
- R5: A write to an empty holding register makes `hold_empty` 0 from the next cycle. If the shifter is idle and transmission is enabled, the byte is transferred on the following edge: `hold_empty` returns to 1 and `tx_out` goes low together, while the frame is still being shifted.
- R6: A byte held while a frame is shifting is transferred on the edge that ends that frame's stop bit. Its start bit follows at once, and `shift_empty` does not rise between the two frames.
- R7: `hold_wr` while `hold_empty` is 0 is ignored. The held byte is not replaced and the ignored byte is never sent.
- R8: Bits are shifted only while `port_en` and `tx_en` are both 1. If either is 0, any frame in progress is abandoned, `tx_out` is 1 on the next cycle, and the holding register keeps its byte until both enables are 1 again.
- R9: `shift_empty` is 1 exactly when no frame is being shifted and the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port master enable |
| tx_en | input | 1 | Transmit enable |
| fast_sel | input | 1 | 1: 16 timer expiries per bit, 0: 64 |
| period_wr | input | 1 | Load strobe for the period register and timer |
| period_din | input | 8 | New timer period |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_din | input | 8 | Byte to transmit |
| hold_empty | output | 1 | Holding register free |
| shift_empty | output | 1 | Shifter idle and holding register free |
| tx_out | output | 1 | Serial line, idles high |

## Verification
The case hardest to reach from the ports is a period write that lands partway through a bit. The bit that results is part old count and part new, and from outside it shows only as a changed pulse width. The stimulus watches `tx_out` fall at a start bit, counts low samples, and pulses `period_wr` at a known sample inside that start bit, so the shortened start bit has an exact predicted length. The moment a queued byte is transferred at the stop-bit boundary is reached by queuing a second byte two cycles after the first and trying a third write while the register is full.

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int DW       = 8,
  parameter int PW       = 8,
  parameter int FAST_OVS = 16,
  parameter int SLOW_OVS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  logic          tx_en,
  input  logic          fast_sel,
  input  logic          period_wr,
  input  logic [PW-1:0] period_din,
  input  logic          hold_wr,
  input  logic [DW-1:0] hold_din,
  output logic          hold_empty,
  output logic          shift_empty,
  output logic          tx_out
);
  localparam int FW   = DW + 2;
  localparam int BCW  = $clog2(FW);
  localparam int SUBW = $clog2(SLOW_OVS);

  logic [PW-1:0]   per_q, cnt_q;
  logic [SUBW-1:0] sub_q;
  logic [FW-1:0]   shf_q;
  logic [BCW-1:0]  bit_q;
  logic            run_q, hfull_q;
  logic [DW-1:0]   hold_q;

  wire             en       = port_en & tx_en;
  wire             tick     = run_q && (cnt_q == '0) && !period_wr;
  wire [SUBW-1:0]  ovs_last = fast_sel ? SUBW'(FAST_OVS - 1) : SUBW'(SLOW_OVS - 1);
  wire             bit_end  = tick && (sub_q == ovs_last);
  wire             last_bit = (bit_q == BCW'(FW - 1));
  wire             load     = en && hfull_q && (!run_q || (bit_end && last_bit));
  wire             take     = hold_wr && !hfull_q;

  assign hold_empty  = !hfull_q;
  assign shift_empty = !run_q && !hfull_q;
  assign tx_out      = !run_q || shf_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      cnt_q <= '0;
    end else if (period_wr) begin
      per_q <= period_din;
      cnt_q <= period_din;
    end else if (!run_q || cnt_q == '0) begin
      cnt_q <= per_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sub_q <= '0;
      bit_q <= '0;
      shf_q <= '1;
    end else if (!en) begin
      run_q <= 1'b0;
      sub_q <= '0;
    end else if (load) begin
      run_q <= 1'b1;
      sub_q <= '0;
      bit_q <= '0;
      shf_q <= {1'b1, hold_q, 1'b0};
    end else if (bit_end) begin
      sub_q <= '0;
      if (last_bit) begin
        run_q <= 1'b0;
      end else begin
        bit_q <= bit_q + 1'b1;
        shf_q <= {1'b1, shf_q[FW-1:1]};
      end
    end else if (tick) begin
      sub_q <= sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hfull_q <= 1'b0;
      hold_q  <= '0;
    end else if (load) begin
      hfull_q <= 1'b0;
    end else if (take) begin
      hfull_q <= 1'b1;
      hold_q  <= hold_din;
    end
  end

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> !tx_out);

  assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !hold_empty);

  assert_drop_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_wr && hfull_q && !load) |=> ($stable(hold_q) && !hold_empty));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_out && !run_q));

  assert_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && last_bit && hfull_q && en) |=> (run_q && !tx_out && !shift_empty));
endmodule

// File: tb/uart_tx_core_test.sv
module uart_tx_core_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0, tx_en = 1'b0, fast_sel = 1'b1;
  logic       period_wr = 1'b0, hold_wr = 1'b0;
  logic [7:0] period_din = 8'h00, hold_din = 8'h00;
  logic       hold_empty, shift_empty, tx_out;

  int checks = 0, fails = 0, cyc = 0;

  uart_tx_core uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en), .fast_sel(fast_sel),
    .period_wr(period_wr), .period_din(period_din), .hold_wr(hold_wr), .hold_din(hold_din),
    .hold_empty(hold_empty), .shift_empty(shift_empty), .tx_out(tx_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  int m_per, m_cnt, m_sub, m_bit;
  bit m_run, m_hf;
  bit [7:0] m_hold, m_data;

  function automatic bit m_line();
    if (!m_run) return 1'b1;
    if (m_bit == 0) return 1'b0;
    if (m_bit == 9) return 1'b1;
    return m_data[m_bit-1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_per = 0; m_cnt = 0; m_sub = 0; m_bit = 0;
      m_run = 0; m_hf = 0; m_hold = 0; m_data = 0;
    end else begin
      automatic bit en = port_en && tx_en;
      automatic int ovs = fast_sel ? 16 : 64;
      automatic bit tk = m_run && m_cnt == 0 && !period_wr;
      automatic bit bend = tk && m_sub == ovs - 1;
      automatic bit was_run = m_run;
      automatic bit ld = en && m_hf && (!m_run || (bend && m_bit == 9));
      automatic bit wr_ok = hold_wr && !m_hf;
      if (!en) begin
        m_run = 0; m_sub = 0;
      end else if (ld) begin
        m_run = 1; m_sub = 0; m_bit = 0; m_data = m_hold;
      end else if (bend) begin
        m_sub = 0;
        if (m_bit == 9) m_run = 0; else m_bit++;
      end else if (tk) begin
        m_sub = (m_sub + 1) % 64;
      end
      if (ld) m_hf = 0;
      else if (wr_ok) begin m_hf = 1; m_hold = hold_din; end
      if (period_wr) begin m_per = period_din; m_cnt = period_din; end
      else if (!was_run || m_cnt == 0) m_cnt = m_per;
      else m_cnt--;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2 tx_out vs model", tx_out, m_line());
    chk("R5 hold_empty vs model", hold_empty, !m_hf);
    chk("R9 shift_empty vs model", shift_empty, !m_run && !m_hf);
  end

  task automatic wr_hold(input logic [7:0] v);
    @(negedge clk); hold_wr = 1'b1; hold_din = v;
    @(negedge clk); hold_wr = 1'b0;
  endtask

  task automatic wr_per(input logic [7:0] v);
    @(negedge clk); period_wr = 1'b1; period_din = v;
    @(negedge clk); period_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && !shift_empty; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic low_width(output int w);
    w = 0;
    for (int i = 0; i < 20000 && tx_out; i++) @(negedge clk);
    while (!tx_out && w < 20000) begin w++; @(negedge clk); end
  endtask

  initial begin
    int w, c0, gaps, lows;
    repeat (3) @(negedge clk);
    chk("R1 reset tx_out", tx_out, 1);
    chk("R1 reset hold_empty", hold_empty, 1);
    chk("R1 reset shift_empty", shift_empty, 1);
    rst_n = 1'b1;
    @(negedge clk);
    port_en = 1'b1; tx_en = 1'b1;

    // R3: fast, P=2 -> 48 cycles per bit
    fast_sel = 1'b1; wr_per(8'd2);
    wr_hold(8'h01); low_width(w);
    chk("R3 fast bit width P=2", w, 48);
    wait_idle();

    // R3: slow, P=1 -> 128 cycles per bit
    fast_sel = 1'b0; wr_per(8'd1);
    wr_hold(8'h01); low_width(w);
    chk("R3 slow bit width P=1", w, 128);
    wait_idle();

    // R5/R6/R7: queued byte, write while full, back-to-back frames
    fast_sel = 1'b1; wr_per(8'd0);
    wr_hold(8'hA5); c0 = cyc;
    @(negedge clk);
    wr_hold(8'h3C);
    chk("R5 hold_empty low after write", hold_empty, 0);
    wr_hold(8'h77);
    chk("R7 hold_empty still low after write while full", hold_empty, 0);
    gaps = 0;
    while (!shift_empty && cyc - c0 < 2000) begin
      @(negedge clk);
    end
    chk("R6 two frames back to back, cycles to drained", cyc - c0, 321);
    wait_idle();

    // R4: period reload during start bit
    wr_per(8'd9); wr_hold(8'hFF);
    for (int i = 0; i < 20000 && tx_out; i++) @(negedge clk);
    w = 0;
    while (!tx_out && w < 20000) begin
      w++;
      if (w == 3) begin period_wr = 1'b1; period_din = 8'd0; end
      else period_wr = 1'b0;
      @(negedge clk);
    end
    period_wr = 1'b0;
    chk("R4 start bit after mid-bit reload", w, 19);
    wait_idle();

    // R8: abort mid-frame and hold while disabled
    wr_hold(8'h00);
    repeat (20) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R8 tx_out high after disable", tx_out, 1);
    chk("R8 shift_empty after abort", shift_empty, 1);
    wr_hold(8'h5A);
    lows = 0;
    repeat (50) begin @(negedge clk); if (!tx_out) lows++; end
    chk("R8 no bits while tx_en low", lows, 0);
    chk("R8 byte kept while disabled", hold_empty, 0);
    port_en = 1'b0; tx_en = 1'b1;
    repeat (30) begin @(negedge clk); if (!tx_out) lows++; end
    chk("R8 no bits while port_en low", lows, 0);
    port_en = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R5 transfer clears hold_empty once enabled", hold_empty, 1);
    chk("R2 start bit after enable", tx_out, 0);
    wait_idle();
    chk("R1 idle line high at end", tx_out, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule